// File: doc/BRIEF.md
# DRAM Address Mapper with Line Buffer

This block sits between a byte-wide read port on the processor side and a 64-bit read port on the memory side. It holds one 8-byte line and answers byte reads that fall inside that line from local storage. A read outside the line is turned into a single 64-bit memory request. The request carries the row, bank and column coordinates of a single-channel, single-rank array that has 4 banks, 16K rows and 1K columns.

The coordinates come from the physical address. The column is taken directly from a contiguous field. The bank bits are scrambled with two row bits. The 14-bit row is assembled from three separate address fields. The low three address bits pick the byte inside the line and never reach the memory.

The processor side uses a valid/ready handshake and allows one request in flight. Address bits above bit 28 are not decoded.

Top module: `dram_line_reader`

## Requirements
- R1: The column output `mem_col` equals physical address bits [12:3].
- R2: Bank bit 0 is addr[13] XOR addr[18], and bank bit 1 is addr[14] XOR addr[19].
- R3: Row bits [10:0] come from addr[26:16], row bit 11 comes from addr[15], and row bits [13:12] come from addr[28:27]. For example, 0x10001FD8 maps to row 8192, bank 0, column 1019.
- R4: Addresses that differ only in bits [2:0] produce an identical memory request. The returned byte is lane addr[2:0] of the 64-bit line, where lane 0 is bits [7:0].
- R5: A miss raises `mem_req` in the cycle after the request is accepted. It keeps `mem_req`, `mem_row`, `mem_bank` and `mem_col` unchanged until the clock edge where `mem_ack` is sampled high, and drops `mem_req` after that edge.
- R6: A read that hits the buffered line (same addr[28:3] as the stored line) raises `rsp_valid` one cycle after acceptance and issues no memory request.
- R7: On a miss, the line is captured from `mem_data` at the `mem_ack` edge. `rsp_valid` is high for the following cycle and carries the selected byte of that data.
- R8: `req_ready` is low from acceptance until the cycle after `rsp_valid`. `rsp_valid` lasts exactly one cycle per request.
- R9: Address bits [31:29] are ignored. An address that differs from the buffered line only in those bits hits.
- R10: Reset empties the buffer and leaves `req_ready` = 1, `rsp_valid` = 0 and `mem_req` = 0. The first read after reset always misses.
- R11: A fetch to a different line replaces the buffered line. A later read of the old line misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Physical byte address |
| rsp_valid | output | 1 | Response byte valid, one cycle |
| rsp_byte | output | 8 | Response byte |
| mem_req | output | 1 | 64-bit memory read request |
| mem_row | output | 14 | Row coordinate |
| mem_bank | output | 2 | Scrambled bank coordinate |
| mem_col | output | 10 | Column coordinate |
| mem_ack | input | 1 | Memory data valid, ends the request |
| mem_data | input | 64 | Line returned by memory |

## Verification
The bench builds the block with its default geometry: a 4-bank, 16K-row, 1K-column array with 8-byte lines. This geometry brings the highest row (16383) and highest column (1023) within reach, as well as scrambled bank values in which the two XOR terms cancel or combine. The bench computes the expected coordinates with division and remainder rather than bit slicing. Its memory model returns a line derived from the requested coordinates, so a wrong field placement also shows up in the returned byte. The bench varies the acknowledge delay per request to exercise the hold-until-acknowledge rule.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;
  localparam int unsigned PADDR_W    = 32;
  localparam int unsigned USED_W     = 29;
  localparam int unsigned LINE_BYTES = 8;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned LINE_W     = LINE_BYTES * BYTE_W;
  localparam int unsigned OFS_W      = $clog2(LINE_BYTES);
  localparam int unsigned COL_W      = 10;
  localparam int unsigned BANK_W     = 2;
  localparam int unsigned ROW_W      = 14;
  localparam int unsigned ROW_LO_W   = 11;
  localparam int unsigned ROW_HI_W   = ROW_W - ROW_LO_W - 1;
  localparam int unsigned TAG_W      = USED_W - OFS_W;
  // bit positions: the decoding order is the behaviour
  localparam int unsigned COL_LSB    = OFS_W;
  localparam int unsigned BANK_LSB   = COL_LSB + COL_W;
  localparam int unsigned ROW_MID    = BANK_LSB + BANK_W;
  localparam int unsigned ROW_LO_LSB = ROW_MID + 1;
  localparam int unsigned ROW_HI_LSB = ROW_LO_LSB + ROW_LO_W;
  localparam int unsigned SCR_LSB    = 18;

  typedef struct packed {
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } dram_coord_t;

  function automatic dram_coord_t map_addr(input logic [PADDR_W-1:0] a);
    dram_coord_t c;
    c.col  = a[COL_LSB +: COL_W];
    c.bank = a[BANK_LSB +: BANK_W] ^ a[SCR_LSB +: BANK_W];
    c.row  = {a[ROW_HI_LSB +: ROW_HI_W], a[ROW_MID], a[ROW_LO_LSB +: ROW_LO_W]};
    return c;
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [PADDR_W-1:0] a);
    return a[OFS_W +: TAG_W];
  endfunction
endpackage

// File: rtl/addr_mapper.sv
module addr_mapper
  import dram_map_pkg::*;
(
  input  logic [PADDR_W-1:0] addr,
  output dram_coord_t        coord,
  output logic [TAG_W-1:0]   tag
);
  assign coord = map_addr(addr);
  assign tag   = line_tag(addr);
endmodule

// File: rtl/line_store.sv
module line_store
  import dram_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_data,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              hit,
  input  logic [OFS_W-1:0]  sel_ofs,
  output logic [BYTE_W-1:0] sel_byte
);
  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] data_q;
  logic [BYTE_W-1:0] lane [LINE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      data_q  <= '0;
    end else if (fill_en) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag;
      data_q  <= fill_data;
    end
  end

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    assign lane[g] = data_q[g*BYTE_W +: BYTE_W];
  end

  assign hit      = valid_q && (tag_q == look_tag);
  assign sel_byte = lane[sel_ofs];

  // R11: a fill makes its own tag hit on the next cycle
  a_r11_fill_hits: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && (look_tag == fill_tag) |=> hit || (look_tag != $past(fill_tag)));
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  input  logic mem_ack,
  output logic req_ready,
  output logic accept,
  output logic mem_req,
  output logic fill_en,
  output logic rsp_valid
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} st_t;
  st_t st_q, st_d;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_req   = (st_q == ST_WAIT);
  assign fill_en   = mem_req && mem_ack;
  assign rsp_valid = (st_q == ST_RESP);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = hit ? ST_RESP : ST_WAIT;
      ST_WAIT: if (mem_ack) st_d = ST_RESP;
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  a_r6_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rsp_valid && !mem_req);
  a_r5_miss_req: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> mem_req && !rsp_valid);
  a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req);
  a_r7_ack_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> rsp_valid && !mem_req);
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: rtl/dram_line_reader.sv
module dram_line_reader
  import dram_map_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PADDR_W-1:0]  req_addr,
  output logic                rsp_valid,
  output logic [BYTE_W-1:0]   rsp_byte,
  output logic                mem_req,
  output logic [ROW_W-1:0]    mem_row,
  output logic [BANK_W-1:0]   mem_bank,
  output logic [COL_W-1:0]    mem_col,
  input  logic                mem_ack,
  input  logic [LINE_W-1:0]   mem_data
);
  logic [PADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]   look_tag, held_tag;
  dram_coord_t        look_coord, held_coord;
  logic               hit, accept, fill_en;
  logic               unused_addr_hi;
  logic [BANK_W+ROW_W+COL_W-1:0] unused_look_coord;

  assign unused_addr_hi    = ^req_addr[PADDR_W-1:USED_W];
  assign unused_look_coord = look_coord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  addr_mapper u_look (.addr(req_addr), .coord(look_coord), .tag(look_tag));
  addr_mapper u_held (.addr(addr_q),   .coord(held_coord), .tag(held_tag));

  fetch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(hit),
    .mem_ack(mem_ack), .req_ready(req_ready), .accept(accept),
    .mem_req(mem_req), .fill_en(fill_en), .rsp_valid(rsp_valid)
  );

  line_store u_line (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_tag(held_tag),
    .fill_data(mem_data), .look_tag(look_tag), .hit(hit),
    .sel_ofs(addr_q[OFS_W-1:0]), .sel_byte(rsp_byte)
  );

  assign mem_row  = held_coord.row;
  assign mem_bank = held_coord.bank;
  assign mem_col  = held_coord.col;

  // R5: coordinates frozen while a request waits
  a_r5_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_row) && $stable(mem_bank) && $stable(mem_col));
  // R8: no response without a prior accept or fill
  a_r8_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !fill_en |=> !rsp_valid);
endmodule

// File: tb/dram_line_reader_bench.sv
`timescale 1ns/1ps
module dram_line_reader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_byte;
  logic        mem_req;
  logic [13:0] mem_row;
  logic [1:0]  mem_bank;
  logic [9:0]  mem_col;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_data = '0;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [13:0] seen_row;
  logic [1:0]  seen_bank;
  logic [9:0]  seen_col;

  always #2 clk = ~clk;

  dram_line_reader u_dram_line_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .mem_req(mem_req), .mem_row(mem_row), .mem_bank(mem_bank), .mem_col(mem_col),
    .mem_ack(mem_ack), .mem_data(mem_data)
  );

  // {expect_hit, address}
  localparam logic [32:0] VEC [12] = '{
    {1'b0, 32'h1000_1FD8}, {1'b1, 32'h1000_1FDB}, {1'b1, 32'h1000_1FDF},
    {1'b1, 32'hF000_1FD9}, {1'b0, 32'h00F0_0010}, {1'b1, 32'h00F0_0017},
    {1'b0, 32'h000C_6000}, {1'b0, 32'h0004_6000}, {1'b0, 32'h1800_8000},
    {1'b0, 32'h00F0_0012}, {1'b0, 32'h1FFF_FFFF}, {1'b1, 32'h1FFF_FFF8}
  };

  function automatic logic [9:0] ref_col(input logic [31:0] a);
    int unsigned u = a;
    return 10'((u / 8) % 1024);
  endfunction
  function automatic logic [1:0] ref_bank(input logic [31:0] a);
    int unsigned u = a;
    return 2'(((u / 8192) % 4) ^ ((u / 262144) % 4));
  endfunction
  function automatic logic [13:0] ref_row(input logic [31:0] a);
    int unsigned u = a;
    return 14'((u / 65536) % 2048 + ((u / 32768) % 2) * 2048 + ((u / 134217728) % 4) * 4096);
  endfunction
  function automatic logic [63:0] line_of(input logic [13:0] r, input logic [1:0] b, input logic [9:0] c);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = 8'(r + c * 3 + b * 17 + i * 37);
    return v;
  endfunction
  function automatic logic [7:0] ref_byte(input logic [31:0] a);
    logic [63:0] l = line_of(ref_row(a), ref_bank(a), ref_col(a));
    return l[a[2:0]*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic read_chk(input logic [31:0] a, input bit exp_hit, input int dly);
    logic [13:0] r0; logic [1:0] b0; logic [9:0] c0;
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      check(rsp_valid && !mem_req, "R6", "hit response next cycle", {rsp_valid, mem_req}, 64'b10);
      check(rsp_byte == ref_byte(a), "R4", "hit byte lane", 64'(rsp_byte), 64'(ref_byte(a)));
    end else begin
      check(mem_req && !rsp_valid && !req_ready, "R5", "miss request", {mem_req, rsp_valid, req_ready}, 64'b100);
      check(mem_col == ref_col(a), "R1", "column", 64'(mem_col), 64'(ref_col(a)));
      check(mem_bank == ref_bank(a), "R2", "bank", 64'(mem_bank), 64'(ref_bank(a)));
      check(mem_row == ref_row(a), "R3", "row", 64'(mem_row), 64'(ref_row(a)));
      r0 = mem_row; b0 = mem_bank; c0 = mem_col;
      seen_row = mem_row; seen_bank = mem_bank; seen_col = mem_col;
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        check(mem_req && {mem_row, mem_bank, mem_col} == {r0, b0, c0} && !req_ready,
              "R5", "held until ack", {mem_req, mem_row, mem_bank, mem_col}, {1'b1, r0, b0, c0});
      end
      mem_ack = 1'b1; mem_data = line_of(r0, b0, c0);
      @(negedge clk);
      mem_ack = 1'b0; mem_data = '0;
      check(!mem_req && rsp_valid, "R7", "response after ack", {mem_req, rsp_valid}, 64'b01);
      check(rsp_byte == ref_byte(a), "R7", "fetched byte", 64'(rsp_byte), 64'(ref_byte(a)));
    end
    @(negedge clk);
    check(!rsp_valid && req_ready, "R8", "single response pulse", {rsp_valid, req_ready}, 64'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "R10", "reset state",
          {req_ready, rsp_valid, mem_req}, 64'b100);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      read_chk(VEC[i][31:0], VEC[i][32], (i % 3) + 1);
      if (i == 0)
        check({seen_row, seen_bank, seen_col} == {14'd8192, 2'd0, 10'd1019}, "R3",
              "worked example 0x10001FD8", {seen_row, seen_bank, seen_col}, {14'd8192, 2'd0, 10'd1019});
      if (i == 9)
        check(seen_col == 10'h002 && seen_row == 14'h00F0, "R4",
              "offset bits not sent", {seen_row, seen_col}, {14'h00F0, 10'h002});
    end
    // R11: line A, line B, then line A again must miss
    read_chk(32'h0000_0040, 1'b0, 1);
    read_chk(32'h0000_0080, 1'b0, 2);
    read_chk(32'h0000_0041, 1'b0, 1);
    // R10: reset mid-run empties the buffer
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "R10", "state in reset",
          {req_ready, rsp_valid, mem_req}, 64'b100);
    rst_n = 1'b1;
    read_chk(32'h0000_0042, 1'b0, 1);
    // R9: only upper bits differ -> hit
    read_chk(32'hE000_0045, 1'b1, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule